// File: doc/BRIEF.md
# Safety Supervisor State Controller with Gated Drive Enable

This block is the supervisory state machine of a safety power-management device. It moves between five states (standby, reset, diagnostic, active and safe) and produces two safety outputs: an active-low reset for the host processor and a drive-enable output that releases external actuators. Rail overvoltage and undervoltage flags, watchdog requests, a safe-state fault request and a one-bit software enable register written through a small write port steer it.

The drive-enable output is a registered AND of the software enable bit with the absence of every blocking condition: an overvoltage on any rail, a watchdog drive-block flag, or any state other than diagnostic or active. Short faults that never move the machine through reset leave the software bit alone, so the drive output comes back by itself once they clear. Leaving reset with the self-test enabled clears the software bit, so software has to arm the drive again. The self-test is modelled as a request/done handshake. A strap input can skip the self-test, and then the bit keeps its value.

Top module: `safety_supervisor`

## Requirements
- R1: While `rst_n` is low and after it rises, `state_o` is 0 (standby), `host_rst_n_o` is 0, `drv_en_o` is 0 and the software enable bit is 0.
- R2: In standby (`state_o`=0), `wake_i` high moves the machine to reset (`state_o`=1) at the next rising edge.
- R3: In diagnostic (2), active (3) or safe (4), `uv_io_i` or `wd_rst_i` high moves the machine to reset at the next edge. Reset is held while `uv_io_i` is high.
- R4: `host_rst_n_o` is 0 exactly when `state_o` is 0 or 1, and `drv_en_o` is 0 in those states.
- R5: `bist_req_o` is high while in reset with `uv_io_i` and `bist_dis_i` low. When `bist_done_i` is also high, the next edge enters diagnostic and clears the enable bit.
- R6: With `bist_dis_i` high, reset with `uv_io_i` low enters diagnostic at the next edge and keeps the enable bit.
- R7: A write (`wr_en_i` high, `wr_addr_i` = 2) loads `wr_data_i` into the enable bit only in diagnostic or active. In every other state it is ignored.
- R8: After each edge, `drv_en_o` equals the enable bit AND (state is 2 or 3) AND no `ov_i` bit set AND `wd_block_i` low, with inputs sampled at that edge. Overvoltage causes no state change.
- R9: `safe_req_i` in diagnostic or active enters safe (4) at the next edge. In safe the drive output is 0 and the only exits are to standby or reset.
- R10: `diag_exit_i` moves diagnostic to active. `sleep_i` moves any non-standby state to standby and has priority over all other requests; `uv_io_i`/`wd_rst_i` outrank `safe_req_i`, which outranks `diag_exit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Leave standby |
| sleep_i | input | 1 | Go to standby |
| ov_i | input | N_RAIL | Per-rail overvoltage flags |
| uv_io_i | input | 1 | Undervoltage on the 3.3/5 V I/O rail |
| wd_block_i | input | 1 | Watchdog drive-block flag |
| wd_rst_i | input | 1 | Watchdog reset request |
| safe_req_i | input | 1 | Safe-state fault request |
| diag_exit_i | input | 1 | Diagnostic-to-active request |
| bist_dis_i | input | 1 | Self-test disable strap |
| bist_done_i | input | 1 | Self-test completion |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 1 | Enable bit write value |
| state_o | output | 3 | Current state code |
| bist_req_o | output | 1 | Self-test request |
| host_rst_n_o | output | 1 | Active-low host reset |
| drv_en_o | output | 1 | Actuator drive enable |

## Verification
`state_o`, `host_rst_n_o` and `drv_en_o` are all registers. Each one shows the effect of an input one rising edge after that input is sampled. `bist_req_o` is combinational and follows the current state and inputs within the same cycle. The bench changes inputs only after it has sampled, 2 ns past each rising edge. Its reference model updates on that same edge, so every comparison lines up with the single-edge latency. Directed sequences cover transient overvoltage, the self-test clear, the strap bypass, ignored writes and request priority. A random phase then exercises the transitions against the model.

// File: rtl/safety_supervisor.sv
`timescale 1ns/1ps
module safety_supervisor #(
  parameter int N_RAIL = 3,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_i,
  input  logic              sleep_i,
  input  logic [N_RAIL-1:0] ov_i,
  input  logic              uv_io_i,
  input  logic              wd_block_i,
  input  logic              wd_rst_i,
  input  logic              safe_req_i,
  input  logic              diag_exit_i,
  input  logic              bist_dis_i,
  input  logic              bist_done_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_data_i,
  output logic [2:0]        state_o,
  output logic              bist_req_o,
  output logic              host_rst_n_o,
  output logic              drv_en_o
);

  typedef enum logic [2:0] {
    ST_STBY = 3'd0, ST_RST = 3'd1, ST_DIAG = 3'd2, ST_ACT = 3'd3, ST_SAFE = 3'd4
  } st_e;

  st_e  st_q, st_d;
  logic en_q, en_d, drv_q, hrst_q;

  wire run_q    = (st_q == ST_DIAG) || (st_q == ST_ACT);
  wire run_d    = (st_d == ST_DIAG) || (st_d == ST_ACT);
  wire rst_req  = uv_io_i | wd_rst_i;
  wire wr_hit   = wr_en_i && (wr_addr_i == CTRL_ADDR) && run_q;
  wire bist_clr = (st_q == ST_RST) && (st_d == ST_DIAG) && !bist_dis_i;

  always_comb begin
    st_d = st_q;
    if (sleep_i && st_q != ST_STBY) st_d = ST_STBY;
    else begin
      case (st_q)
        ST_STBY: if (wake_i) st_d = ST_RST;
        ST_RST:  if (!uv_io_i && (bist_dis_i || bist_done_i)) st_d = ST_DIAG;
        ST_DIAG, ST_ACT: begin
          if (rst_req)                              st_d = ST_RST;
          else if (safe_req_i)                      st_d = ST_SAFE;
          else if (st_q == ST_DIAG && diag_exit_i)  st_d = ST_ACT;
        end
        ST_SAFE: if (rst_req) st_d = ST_RST;
        default: st_d = ST_STBY;
      endcase
    end
  end

  assign en_d = bist_clr ? 1'b0 : (wr_hit ? wr_data_i : en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_STBY;
      en_q   <= 1'b0;
      drv_q  <= 1'b0;
      hrst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      drv_q  <= en_d && run_d && !(|ov_i) && !wd_block_i;
      hrst_q <= !((st_d == ST_STBY) || (st_d == ST_RST));
    end
  end

  assign state_o      = st_q;
  assign bist_req_o   = (st_q == ST_RST) && !uv_io_i && !bist_dis_i;
  assign host_rst_n_o = hrst_q;
  assign drv_en_o     = drv_q;

  a_r4_reset_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STBY || st_q == ST_RST) |-> (!hrst_q && !drv_q));
  a_r5_bist_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RST && !bist_dis_i) |=> (st_q != ST_DIAG || !en_q));
  a_r6_bypass_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RST && bist_dis_i && !uv_io_i && !sleep_i) |=> (st_q == ST_DIAG && en_q == $past(en_q)));
  a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STBY || st_q == ST_SAFE) |=> $stable(en_q));
  a_r8_fault_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ov_i) || wd_block_i) |=> !drv_q);
  a_r9_safe_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SAFE) |-> (!drv_q && hrst_q));
  a_r9_safe_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SAFE) |=> (st_q == ST_SAFE || st_q == ST_STBY || st_q == ST_RST));

endmodule

// File: tb/sim_safety_supervisor.sv
`timescale 1ns/1ps
module sim_safety_supervisor;
  logic clk = 0, rst_n = 0;
  logic wake, sleep, uv, wdb, wdr, safe, dexit, bdis, bdone, wr, wd;
  logic [2:0] ov;
  logic [3:0] wa;
  logic [2:0] state;
  logic breq, hrst, drv;
  int tests = 0, fails = 0;
  int m_st; bit m_en, m_drv, m_hr;

  always #4 clk = ~clk;

  safety_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .sleep_i(sleep), .ov_i(ov),
    .uv_io_i(uv), .wd_block_i(wdb), .wd_rst_i(wdr), .safe_req_i(safe),
    .diag_exit_i(dexit), .bist_dis_i(bdis), .bist_done_i(bdone),
    .wr_en_i(wr), .wr_addr_i(wa), .wr_data_i(wd), .state_o(state),
    .bist_req_o(breq), .host_rst_n_o(hrst), .drv_en_o(drv));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_drv = 0; m_hr = 0;
    end else begin
      int ns; bit ne;
      ns = m_st; ne = m_en;
      if (wr && wa == 2 && (m_st == 2 || m_st == 3)) ne = wd;
      if (sleep && m_st != 0) ns = 0;
      else if (m_st == 0 && wake) ns = 1;
      else if (m_st == 1 && !uv && (bdis || bdone)) begin
        ns = 2;
        if (!bdis) ne = 0;
      end
      else if ((m_st >= 2) && (uv || wdr)) ns = 1;
      else if ((m_st == 2 || m_st == 3) && safe) ns = 4;
      else if (m_st == 2 && dexit) ns = 3;
      m_st = ns; m_en = ne;
      m_drv = ne && (ns == 2 || ns == 3) && ov == 0 && !wdb;
      m_hr = !(ns == 0 || ns == 1);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    chk("R3 R10 state_o", state, m_st);
    chk("R4 host_rst_n_o", hrst, m_hr);
    chk("R8 drv_en_o", drv, m_drv);
    chk("R5 bist_req_o", breq, (m_st == 1 && !uv && !bdis));
  endtask

  task automatic idle();
    {wake, sleep, uv, wdb, wdr, safe, dexit, bdone, wr, wd} = '0;
    ov = 0; wa = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 50000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(); bdis = 0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 reset state", state, 0);
    chk("R1 reset host_rst", hrst, 0);
    chk("R1 reset drv", drv, 0);
    rst_n = 1;
    tick();
    chk("R1 standby held", state, 0);
    wake = 1; tick(); wake = 0;
    chk("R2 wake to reset", state, 1);
    uv = 1; tick(); tick();
    chk("R3 uv holds reset", state, 1);
    chk("R5 no bist_req under uv", breq, 0);
    uv = 0; #1;
    chk("R5 bist_req raised", breq, 1);
    wr = 1; wa = 2; wd = 1; tick(); wr = 0;
    chk("R7 write in reset ignored state", state, 1);
    bdone = 1; tick(); bdone = 0;
    chk("R5 enter diagnostic", state, 2);
    chk("R7 drive off without write", drv, 0);
    chk("R4 host reset released", hrst, 1);
    wr = 1; wa = 2; wd = 1; tick(); wr = 0;
    chk("R7 write sets enable", drv, 1);
    ov = 3'b010; tick(); tick();
    chk("R8 ov blocks drive", drv, 0);
    chk("R8 ov no state change", state, 2);
    ov = 0; tick();
    chk("R8 drive returns", drv, 1);
    wdb = 1; tick(); wdb = 0;
    chk("R8 wd block", drv, 0);
    dexit = 1; tick(); dexit = 0;
    chk("R10 diag to active", state, 3);
    chk("R10 drive in active", drv, 1);
    safe = 1; dexit = 1; tick(); safe = 0; dexit = 0;
    chk("R9 enter safe", state, 4);
    chk("R9 safe drive low", drv, 0);
    wr = 1; wa = 2; wd = 0; tick(); wr = 0;
    chk("R9 stay safe", state, 4);
    bdis = 1; wdr = 1; safe = 1; tick(); wdr = 0; safe = 0;
    chk("R3 safe to reset", state, 1);
    tick();
    chk("R6 bypass one clock", state, 2);
    chk("R6 R7 enable kept", drv, 1);
    bdis = 0; uv = 1; tick(); uv = 0;
    chk("R3 diag uv to reset", state, 1);
    bdone = 1; tick(); bdone = 0;
    chk("R5 enable cleared", drv, 0);
    sleep = 1; tick(); sleep = 0;
    chk("R10 sleep to standby", state, 0);
    wr = 1; wa = 2; wd = 1; tick(); wr = 0;
    bdis = 1; wake = 1; tick(); wake = 0; tick();
    chk("R7 standby write ignored", drv, 0);
    wr = 1; wa = 2; wd = 1; dexit = 1; tick(); wr = 0; dexit = 0;
    sleep = 1; uv = 1; safe = 1; tick(); sleep = 0; uv = 0; safe = 0;
    chk("R10 sleep priority", state, 0);
    bdis = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) bdis = $urandom_range(0, 2) == 0;
      wake  = $urandom_range(0, 3) == 0;
      sleep = $urandom_range(0, 79) == 0;
      uv    = $urandom_range(0, 39) == 0;
      wdr   = $urandom_range(0, 79) == 0;
      safe  = $urandom_range(0, 79) == 0;
      dexit = $urandom_range(0, 7) == 0;
      bdone = $urandom_range(0, 3) == 0;
      wdb   = $urandom_range(0, 15) == 0;
      ov    = ($urandom_range(0, 11) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      wr    = $urandom_range(0, 3) == 0;
      wa    = 4'($urandom_range(0, 3));
      wd    = $urandom_range(0, 2) != 0;
      tick();
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule